// File: doc/BRIEF.md
# Accumulator Machine Timing Controller

This block is the sequencing and control unit of a 16-bit machine that keeps one accumulator and uses 12-bit addresses. A step counter, decoded into one-hot timing steps, paces every instruction through fetch, decode, an optional indirect-address step and one to three execute steps. On each step the block looks at the registered instruction word, the indirect flip-flop and a few status bits from the datapath. From these it raises the register load, clear and increment strobes, the memory read and write strobes, and the 3-bit source select of the shared bus.

A pending-interrupt flip-flop is set between instructions when interrupts are enabled and either I/O flag is up. When it is set, the next three steps run a hardware call that saves the program counter at address 0 and resumes at address 1. A halt instruction clears an internal run flag. From then on the counter freezes and every strobe stays low until reset. The datapath registers, the memory array and the ALU sit outside this block and see only its strobes.

Top module: `acm_timing_ctrl`

## Requirements
- R1: `step` is 0 after reset. It advances by one on every clock while running and returns to 0 after the last step of each instruction. Register and I/O instructions (opcode `ir_word[14:12]`=7) end at step 3. STA (3) and BUN (4) end at step 4. AND (0), ADD (1), LDA (2) and BSA (5) end at step 5. ISZ (6) ends at step 6. The interrupt cycle ends at step 2.
- R2: With no interrupt pending, step 0 loads AR from PC. Step 1 reads memory, loads IR and increments PC. Step 2 loads AR from IR and captures `ir_word[15]` as the indirect bit.
- R3: `ar_ld` is the OR of (no interrupt, step 0), (no interrupt, step 2) and (opcode not 7, indirect, step 3). `ar_clr` is (interrupt, step 0). `ar_inc` is (opcode 5, step 4).
- R4: `pc_ld` is raised by BUN at step 4 and by BSA at step 5. `pc_clr` is raised at interrupt step 1. `pc_inc` is raised at fetch step 1, at interrupt step 2, by ISZ at step 6 when `dr_is_zero`=1, and by the skip tests at step 3 (see R6 and R7).
- R5: `dr_ld` is raised at step 4 for opcodes 0, 1, 2 and 6. `dr_inc` is raised by ISZ at step 5. `tr_ld` is raised at interrupt step 0. `outr_ld` is raised by the I/O instruction with bit 10 set.
- R6: A register instruction (opcode 7, indirect 0, step 3) acts on each set bit of `ir_word`. Bit 11 gives `ac_op[7]` (clear). Bit 10 gives `e_clr`. Bit 9 gives `ac_op[4]` (complement). Bit 8 gives `e_cmp`. Bit 7 gives `ac_op[5]` (rotate right). Bit 6 gives `ac_op[6]` (rotate left). Bit 5 gives `ac_op[8]` (increment). Bit 0 halts the machine. Bits 4, 3, 2 and 1 raise `pc_inc` when, in that order, `ac_msb`=0, `ac_msb`=1, `ac_is_zero`=1 or `e_flag`=0. At step 5, AND, ADD and LDA raise `ac_op[0]`, `ac_op[1]` and `ac_op[2]`.
- R7: An I/O instruction (opcode 7, indirect 1, step 3) acts on each set bit of `ir_word`. Bit 11 gives `ac_op[3]` and `fgi_clr`. Bit 10 gives `fgo_clr`. Bit 7 gives `ien_set`. Bit 6 gives `ien_clr`. Bits 9 and 8 raise `pc_inc` when `in_flag` or `out_flag` is 1. `ien_clr` is also raised at interrupt step 2.
- R8: `mem_rd` is raised at fetch step 1, at the indirect step 3, and at step 4 for opcodes 0, 1, 2 and 6. `mem_wr` is raised at interrupt step 1, at step 4 for opcodes 3 and 5, and by ISZ at step 6. The two are never raised together.
- R9: `bus_sel` codes are AR=1, PC=2, DR=3, AC=4, IR=5, TR=6, memory=7 and none=0. At most one source is requested in any step.
- R10: `irq_pend` is set one clock after a running step other than 0, 1 or 2 in which `int_en`=1 and `in_flag` or `out_flag` is 1.
- R11: While `irq_pend`=1, steps 0 to 2 run the interrupt cycle. Step 2 raises `pc_inc` and `ien_clr`. The next clock brings `step` to 0 and `irq_pend` to 0.
- R12: Reset gives `step`=0, `irq_pend`=0 and `running`=1. After a halt, `running` is 0, `step` holds, and no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_word | input | 16 | Instruction register contents |
| dr_is_zero | input | 1 | Data register equals zero |
| ac_msb | input | 1 | Accumulator sign bit |
| ac_is_zero | input | 1 | Accumulator equals zero |
| e_flag | input | 1 | Carry/extend bit |
| in_flag | input | 1 | Input-ready flag |
| out_flag | input | 1 | Output-ready flag |
| int_en | input | 1 | Interrupt enable flip-flop |
| step | output | SC_W | Current timing step |
| irq_pend | output | 1 | Pending-interrupt flip-flop |
| running | output | 1 | Run flag |
| ar_ld | output | 1 | AR load |
| ar_clr | output | 1 | AR clear |
| ar_inc | output | 1 | AR increment |
| pc_ld | output | 1 | PC load |
| pc_clr | output | 1 | PC clear |
| pc_inc | output | 1 | PC increment |
| dr_ld | output | 1 | DR load |
| dr_inc | output | 1 | DR increment |
| ir_ld | output | 1 | IR load |
| tr_ld | output | 1 | TR load |
| outr_ld | output | 1 | Output register load |
| ac_op | output | 9 | Accumulator operation strobes |
| e_clr | output | 1 | Clear E |
| e_cmp | output | 1 | Complement E |
| ien_set | output | 1 | Set interrupt enable |
| ien_clr | output | 1 | Clear interrupt enable |
| fgi_clr | output | 1 | Clear input flag |
| fgo_clr | output | 1 | Clear output flag |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| bus_sel | output | 3 | Bus source select |

## Verification
Every strobe and `bus_sel` is a combinational function of state captured at the previous rising edge and of the present inputs, so it is due in the same cycle in which the inputs are applied. `step`, `irq_pend`, `running` and the indirect bit change exactly one edge later. The bench applies inputs on the falling edge and samples 1 ns later. It compares the outputs against a step model, and only then advances that model by one clock. The instruction word is changed only in a model step 2 with no interrupt pending, which is the cycle after IR would have been loaded.

// File: rtl/acm_pkg.sv
package acm_pkg;
  localparam int OPC_W = 3;
  localparam int OPC_N = 1 << OPC_W;

  localparam int AO_AND = 0;
  localparam int AO_ADD = 1;
  localparam int AO_XFR = 2;
  localparam int AO_INP = 3;
  localparam int AO_CMA = 4;
  localparam int AO_SHR = 5;
  localparam int AO_SHL = 6;
  localparam int AO_CLR = 7;
  localparam int AO_INC = 8;
  localparam int AO_N   = 9;

  localparam int BUS_W = 3;
  localparam int SRC_N = 1 << BUS_W;

  typedef enum logic [BUS_W-1:0] {
    SRC_NONE = 3'd0,
    SRC_AR   = 3'd1,
    SRC_PC   = 3'd2,
    SRC_DR   = 3'd3,
    SRC_AC   = 3'd4,
    SRC_IR   = 3'd5,
    SRC_TR   = 3'd6,
    SRC_MEM  = 3'd7
  } bus_src_e;
endpackage

// File: rtl/acm_step_ctr.sv
module acm_step_ctr #(
  parameter int SC_W = 3,
  localparam int T_N = 1 << SC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic            clr,
  output logic [SC_W-1:0] sc,
  output logic [T_N-1:0]  t_vec
);
  logic [SC_W-1:0] sc_q;
  logic [SC_W-1:0] sc_d;

  always_comb begin
    sc_d = clr ? '0 : sc_q + SC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sc_q <= '0;
    else if (!hold) sc_q <= sc_d;
  end

  for (genvar k = 0; k < T_N; k++) begin : g_tdec
    assign t_vec[k] = (sc_q == SC_W'(k));
  end

  assign sc = sc_q;

  // R1
  clear_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && clr) |=> (sc_q == '0));
endmodule

// File: rtl/acm_ctrl_flops.sv
module acm_ctrl_flops (
  input  logic clk,
  input  logic rst_n,
  input  logic r_set,
  input  logic r_clr,
  input  logic halt_req,
  input  logic i_ld,
  input  logic i_bit,
  output logic r_q,
  output logic run_q,
  output logic i_q
);
  logic r_d;
  logic run_d;
  logic i_d;

  always_comb begin
    r_d = r_q;
    if (r_clr) r_d = 1'b0;
    else if (r_set) r_d = 1'b1;
    run_d = run_q & ~halt_req;
    i_d = i_ld ? i_bit : i_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q   <= 1'b0;
      run_q <= 1'b1;
      i_q   <= 1'b0;
    end else begin
      r_q   <= r_d;
      run_q <= run_d;
      i_q   <= i_d;
    end
  end

  // R11
  r_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_clr |=> !r_q);
endmodule

// File: rtl/acm_strobe_gen.sv
module acm_strobe_gen
  import acm_pkg::*;
#(
  parameter int T_N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [T_N-1:0]   t,
  input  logic [OPC_N-1:0] d,
  input  logic             i_q,
  input  logic             r_q,
  input  logic             run,
  input  logic [11:0]      ir_bits,
  input  logic             dr_zero,
  input  logic             ac_msb,
  input  logic             ac_zero,
  input  logic             e_flag,
  input  logic             fgi,
  input  logic             fgo,
  input  logic             ien,
  output logic             ar_ld,
  output logic             ar_clr,
  output logic             ar_inc,
  output logic             pc_ld,
  output logic             pc_clr,
  output logic             pc_inc,
  output logic             dr_ld,
  output logic             dr_inc,
  output logic             ir_ld,
  output logic             tr_ld,
  output logic             outr_ld,
  output logic [AO_N-1:0]  ac_op,
  output logic             e_clr,
  output logic             e_cmp,
  output logic             ien_set,
  output logic             ien_clr,
  output logic             fgi_clr,
  output logic             fgo_clr,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic [BUS_W-1:0] bus_sel,
  output logic             sc_clr,
  output logic             r_set,
  output logic             r_clr,
  output logic             halt_req,
  output logic             i_ld
);
  logic [T_N-1:0]   tg;
  logic [SRC_N-1:0] src_req;
  logic reg_x, io_x, fet0, fet1, dec, int0, int1, int2, ind, rd4;
  logic skip_reg, skip_io;

  always_comb begin
    tg   = run ? t : '0;
    reg_x = tg[3] & d[7] & ~i_q;
    io_x  = tg[3] & d[7] &  i_q;
    fet0 = tg[0] & ~r_q;
    fet1 = tg[1] & ~r_q;
    dec  = tg[2] & ~r_q;
    int0 = tg[0] & r_q;
    int1 = tg[1] & r_q;
    int2 = tg[2] & r_q;
    ind  = tg[3] & ~d[7] & i_q;
    rd4  = tg[4] & (d[0] | d[1] | d[2] | d[6]);

    skip_reg = reg_x & ((ir_bits[4] & ~ac_msb) | (ir_bits[3] & ac_msb) |
                        (ir_bits[2] & ac_zero) | (ir_bits[1] & ~e_flag));
    skip_io  = io_x & ((ir_bits[9] & fgi) | (ir_bits[8] & fgo));

    ar_ld  = fet0 | dec | ind;
    ar_clr = int0;
    ar_inc = d[5] & tg[4];
    pc_ld  = (d[4] & tg[4]) | (d[5] & tg[5]);
    pc_clr = int1;
    pc_inc = fet1 | int2 | skip_reg | skip_io | (d[6] & tg[6] & dr_zero);
    dr_ld  = rd4;
    dr_inc = d[6] & tg[5];
    ir_ld  = fet1;
    tr_ld  = int0;
    outr_ld = io_x & ir_bits[10];

    ac_op         = '0;
    ac_op[AO_AND] = d[0] & tg[5];
    ac_op[AO_ADD] = d[1] & tg[5];
    ac_op[AO_XFR] = d[2] & tg[5];
    ac_op[AO_INP] = io_x & ir_bits[11];
    ac_op[AO_CMA] = reg_x & ir_bits[9];
    ac_op[AO_SHR] = reg_x & ir_bits[7];
    ac_op[AO_SHL] = reg_x & ir_bits[6];
    ac_op[AO_CLR] = reg_x & ir_bits[11];
    ac_op[AO_INC] = reg_x & ir_bits[5];

    e_clr   = reg_x & ir_bits[10];
    e_cmp   = reg_x & ir_bits[8];
    ien_set = io_x & ir_bits[7];
    ien_clr = (io_x & ir_bits[6]) | int2;
    fgi_clr = io_x & ir_bits[11];
    fgo_clr = io_x & ir_bits[10];

    mem_rd = fet1 | ind | rd4;
    mem_wr = int1 | (tg[4] & (d[3] | d[5])) | (d[6] & tg[6]);

    src_req          = '0;
    src_req[SRC_AR]  = (d[4] & tg[4]) | (d[5] & tg[5]);
    src_req[SRC_PC]  = fet0 | int0 | (d[5] & tg[4]);
    src_req[SRC_DR]  = d[6] & tg[6];
    src_req[SRC_AC]  = (d[3] & tg[4]) | outr_ld;
    src_req[SRC_IR]  = dec;
    src_req[SRC_TR]  = int1;
    src_req[SRC_MEM] = mem_rd;

    bus_sel = '0;
    for (int k = 1; k < SRC_N; k++) begin
      if (src_req[k]) bus_sel = bus_sel | BUS_W'(k);
    end

    sc_clr = reg_x | io_x | (tg[4] & (d[3] | d[4])) |
             (tg[5] & (d[0] | d[1] | d[2] | d[5])) | (tg[6] & d[6]) |
             int2 | tg[T_N-1];
    r_set    = run & ien & (fgi | fgo) & ~(t[0] | t[1] | t[2]);
    r_clr    = int2;
    halt_req = reg_x & ir_bits[0];
    i_ld     = dec;
  end

  // R9
  bus_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_req));
endmodule

// File: rtl/acm_timing_ctrl.sv
module acm_timing_ctrl
  import acm_pkg::*;
#(
  parameter int SC_W = 3,
  localparam int T_N = 1 << SC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      ir_word,
  input  logic             dr_is_zero,
  input  logic             ac_msb,
  input  logic             ac_is_zero,
  input  logic             e_flag,
  input  logic             in_flag,
  input  logic             out_flag,
  input  logic             int_en,
  output logic [SC_W-1:0]  step,
  output logic             irq_pend,
  output logic             running,
  output logic             ar_ld,
  output logic             ar_clr,
  output logic             ar_inc,
  output logic             pc_ld,
  output logic             pc_clr,
  output logic             pc_inc,
  output logic             dr_ld,
  output logic             dr_inc,
  output logic             ir_ld,
  output logic             tr_ld,
  output logic             outr_ld,
  output logic [AO_N-1:0]  ac_op,
  output logic             e_clr,
  output logic             e_cmp,
  output logic             ien_set,
  output logic             ien_clr,
  output logic             fgi_clr,
  output logic             fgo_clr,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic [BUS_W-1:0] bus_sel
);
  logic [T_N-1:0]   t_vec;
  logic [OPC_N-1:0] opc_dec;
  logic sc_clr, r_set, r_clr, halt_req, i_ld, i_q;

  for (genvar k = 0; k < OPC_N; k++) begin : g_opdec
    assign opc_dec[k] = (ir_word[14:12] == OPC_W'(k));
  end

  acm_step_ctr #(.SC_W(SC_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .hold(~running), .clr(sc_clr),
    .sc(step), .t_vec(t_vec)
  );

  acm_ctrl_flops u_flops (
    .clk(clk), .rst_n(rst_n), .r_set(r_set), .r_clr(r_clr),
    .halt_req(halt_req), .i_ld(i_ld), .i_bit(ir_word[15]),
    .r_q(irq_pend), .run_q(running), .i_q(i_q)
  );

  acm_strobe_gen #(.T_N(T_N)) u_strb (
    .clk(clk), .rst_n(rst_n), .t(t_vec), .d(opc_dec), .i_q(i_q),
    .r_q(irq_pend), .run(running), .ir_bits(ir_word[11:0]),
    .dr_zero(dr_is_zero), .ac_msb(ac_msb), .ac_zero(ac_is_zero),
    .e_flag(e_flag), .fgi(in_flag), .fgo(out_flag), .ien(int_en),
    .ar_ld(ar_ld), .ar_clr(ar_clr), .ar_inc(ar_inc),
    .pc_ld(pc_ld), .pc_clr(pc_clr), .pc_inc(pc_inc),
    .dr_ld(dr_ld), .dr_inc(dr_inc), .ir_ld(ir_ld), .tr_ld(tr_ld),
    .outr_ld(outr_ld), .ac_op(ac_op), .e_clr(e_clr), .e_cmp(e_cmp),
    .ien_set(ien_set), .ien_clr(ien_clr), .fgi_clr(fgi_clr),
    .fgo_clr(fgo_clr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .bus_sel(bus_sel), .sc_clr(sc_clr), .r_set(r_set), .r_clr(r_clr),
    .halt_req(halt_req), .i_ld(i_ld)
  );

  // R1
  step_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(step) <= 6);

  // R8
  mem_rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pend) |-> (int'($past(step)) >= 3));

  // R11
  int_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && running && int'(step) == 2) |=> (step == '0 && !irq_pend));

  // R12
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> ($stable(step) && !mem_rd && !mem_wr && bus_sel == '0));
endmodule

// File: tb/sim_acm_timing_ctrl.sv
`timescale 1ns/1ps
module sim_acm_timing_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] ir_word;
  logic dr_is_zero, ac_msb, ac_is_zero, e_flag, in_flag, out_flag, int_en;
  logic [2:0]  step;
  logic irq_pend, running, ar_ld, ar_clr, ar_inc, pc_ld, pc_clr, pc_inc;
  logic dr_ld, dr_inc, ir_ld, tr_ld, outr_ld;
  logic [8:0]  ac_op;
  logic e_clr, e_cmp, ien_set, ien_clr, fgi_clr, fgo_clr, mem_rd, mem_wr;
  logic [2:0]  bus_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int m_sc;
  bit m_r, m_run, m_i;

  always #2.5 clk = ~clk;

  acm_timing_ctrl u0 (.*);

  // expected outputs from the step model
  logic [7:0] xt, xd;
  logic xreg, xio, xf0, xf1, xdc, xi0, xi1, xi2, xind, xrd4, xclr;
  logic [2:0] x_ar, x_pc, x_bus;
  logic [4:0] x_ld;
  logic [8:0] x_ac;
  logic [5:0] x_fl;
  logic [1:0] x_mem;

  always_comb begin
    xt   = m_run ? (8'd1 << m_sc) : 8'd0;
    xd   = 8'd1 << ir_word[14:12];
    xreg = xt[3] & xd[7] & ~m_i;
    xio  = xt[3] & xd[7] & m_i;
    xf0 = xt[0] & ~m_r; xf1 = xt[1] & ~m_r; xdc = xt[2] & ~m_r;
    xi0 = xt[0] & m_r;  xi1 = xt[1] & m_r;  xi2 = xt[2] & m_r;
    xind = xt[3] & ~xd[7] & m_i;
    xrd4 = xt[4] & (xd[0] | xd[1] | xd[2] | xd[6]);
    x_ar = {xf0 | xdc | xind, xi0, xd[5] & xt[4]};
    x_pc = {(xd[4] & xt[4]) | (xd[5] & xt[5]), xi1,
            xf1 | xi2 | (xd[6] & xt[6] & dr_is_zero) |
            (xreg & ir_word[4] & !ac_msb) | (xreg & ir_word[3] & ac_msb) |
            (xreg & ir_word[2] & ac_is_zero) | (xreg & ir_word[1] & !e_flag) |
            (xio & ir_word[9] & in_flag) | (xio & ir_word[8] & out_flag)};
    x_ld = {xrd4, xd[6] & xt[5], xf1, xi0, xio & ir_word[10]};
    x_ac = {xreg & ir_word[5], xreg & ir_word[11], xreg & ir_word[6],
            xreg & ir_word[7], xreg & ir_word[9], xio & ir_word[11],
            xd[2] & xt[5], xd[1] & xt[5], xd[0] & xt[5]};
    x_fl = {xreg & ir_word[10], xreg & ir_word[8], xio & ir_word[7],
            (xio & ir_word[6]) | xi2, xio & ir_word[11], xio & ir_word[10]};
    x_mem = {xf1 | xind | xrd4, xi1 | (xt[4] & (xd[3] | xd[5])) | (xd[6] & xt[6])};
    if (xf1 | xind | xrd4)                   x_bus = 3'd7;
    else if (xf0 | xi0 | (xd[5] & xt[4]))    x_bus = 3'd2;
    else if (xdc)                            x_bus = 3'd5;
    else if (xi1)                            x_bus = 3'd6;
    else if ((xd[3] & xt[4]) | (xio & ir_word[10])) x_bus = 3'd4;
    else if (xd[6] & xt[6])                  x_bus = 3'd3;
    else if ((xd[4] & xt[4]) | (xd[5] & xt[5])) x_bus = 3'd1;
    else                                     x_bus = 3'd0;
    xclr = xreg | xio | (xt[4] & (xd[3] | xd[4])) |
           (xt[5] & (xd[0] | xd[1] | xd[2] | xd[5])) | (xt[6] & xd[6]) | xi2;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (model step %0d)", tag, act, exp, m_sc);
    end
  endtask

  task automatic check_all();
    chk("R1 step", 32'(step), 32'(m_sc));
    chk("R10 irq_pend", 32'(irq_pend), 32'(m_r));
    chk("R12 running", 32'(running), 32'(m_run));
    chk("R3 ar strobes", 32'({ar_ld, ar_clr, ar_inc}), 32'(x_ar));
    chk("R4 pc strobes", 32'({pc_ld, pc_clr, pc_inc}), 32'(x_pc));
    chk("R5 loads", 32'({dr_ld, dr_inc, ir_ld, tr_ld, outr_ld}), 32'(x_ld));
    chk("R6 ac_op", 32'(ac_op), 32'(x_ac));
    chk("R7 flag strobes", 32'({e_clr, e_cmp, ien_set, ien_clr, fgi_clr, fgo_clr}), 32'(x_fl));
    chk("R8 memory strobes", 32'({mem_rd, mem_wr}), 32'(x_mem));
    chk("R9 bus_sel", 32'(bus_sel), 32'(x_bus));
    if (m_run && !m_r && m_sc == 1)
      chk("R2 fetch read", 32'({ir_ld, mem_rd, pc_inc, bus_sel}), 32'({3'b111, 3'd7}));
    if (m_run && m_r && m_sc == 2)
      chk("R11 interrupt exit", 32'({pc_inc, ien_clr, mem_wr}), 32'(3'b110));
  endtask

  task automatic advance_model();
    int  sc0 = m_sc;
    bit  r0  = m_r;
    bit  c0  = xclr;
    bit  h0  = xreg & ir_word[0];
    if (m_run) begin
      m_sc = c0 ? 0 : (sc0 + 1) % 8;
      if (r0 && sc0 == 2) m_r = 1'b0;
      else if (int_en && (in_flag || out_flag) && sc0 >= 3) m_r = 1'b1;
      if (!r0 && sc0 == 2) m_i = ir_word[15];
      if (h0) m_run = 1'b0;
    end
  endtask

  function automatic logic [15:0] rand_instr();
    logic [2:0] opc = 3'($urandom_range(0, 7));
    logic       ib  = 1'($urandom_range(0, 1));
    if (opc != 3'd7) return {ib, opc, 12'($urandom)};
    if (!ib) begin
      if ($urandom_range(0, 1) == 0) return {4'h7, 12'h1 << $urandom_range(1, 11)};
      return {4'h7, 12'($urandom) & 12'hFFE};
    end
    return {4'hF, 6'($urandom), 6'd0};
  endfunction

  task automatic drive(input bit halt_phase);
    dr_is_zero = 1'($urandom);
    ac_msb     = 1'($urandom);
    ac_is_zero = 1'($urandom);
    e_flag     = 1'($urandom);
    in_flag    = 1'($urandom);
    out_flag   = 1'($urandom);
    int_en     = halt_phase ? 1'b0 : ($urandom_range(0, 3) == 0);
    if (m_run && !m_r && m_sc == 2)
      ir_word = halt_phase ? 16'h7001 : rand_instr();
  endtask

  initial begin
    void'($urandom(32'h1A2B3C4D));
    rst_n = 1'b0;
    ir_word = 16'h0000;
    {dr_is_zero, ac_msb, ac_is_zero, e_flag, in_flag, out_flag, int_en} = '0;
    m_sc = 0; m_r = 0; m_run = 1; m_i = 0;
    repeat (3) @(negedge clk);
    #1;
    // R12 reset state
    chk("R12 reset step", 32'(step), 32'd0);
    chk("R12 reset irq", 32'(irq_pend), 32'd0);
    chk("R12 reset run", 32'(running), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    // directed first fetch step, no interrupt
    #1;
    chk("R2 first fetch", 32'({ar_ld, bus_sel}), 32'({1'b1, 3'd2}));
    advance_model();
    @(negedge clk);
    for (int cyc = 0; cyc < 4000; cyc++) begin
      drive(cyc >= 3500);
      #1;
      check_all();
      advance_model();
      @(negedge clk);
    end
    // R12 halted: nothing moves
    chk("R12 halted", 32'({running, mem_rd, mem_wr, bus_sel}), 32'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule